// File: doc/BRIEF.md
# Vector Single-Precision Greater-Than Comparator

This block compares two 128-bit vectors holding four IEEE-754 single-precision lanes. For every lane it produces a mask word of all ones when the lane of operand A is strictly greater than the lane of operand B, and all zeros otherwise. Unordered lanes (either side a NaN) always give zero. The result registers one cycle after an accepted operation.

Alongside the mask, the block sorts NaNs into signaling and quiet kinds and raises two per-operation invalid flags: one for signaling NaNs and one for an invalid compare. When the invalid-exception enable is set and any lane raises a flag, the block drops the target write-enable. When recording is requested, it also produces a 4-bit condition summary that reports whether every lane or no lane compared greater. Three sticky status bits collect the flags across operations until reset.

Top module: `vsp_gt_cmp`

## Requirements
- R1: Lane i is bits [32i+31:32i] of each operand and of mask_o. An operation is accepted when valid_i is 1. One cycle later valid_o is 1 and each mask lane holds 0xFFFFFFFF if A>B in that lane, else 0x00000000.
- R2: The compare follows real-number order over normals, denormals (taken by value, not flushed) and infinities. For two negative operands the order of the magnitudes is reversed.
- R3: +0 and -0 compare equal, so a lane holding only zeros gives a zero mask lane.
- R4: A NaN has exponent bits [30:23] all ones and a nonzero fraction. It is quiet when bit 22 is 1 and signaling when bit 22 is 0. Any lane with a NaN operand gives a zero mask lane.
- R5: The signaling flag is raised when either operand in any lane is a signaling NaN. The invalid-compare flag is raised by a lane with a signaling NaN only when inv_en_i is 0. A lane with no signaling NaN raises it when either operand is a quiet NaN.
- R6: An exception occurs when inv_en_i is 1 and any lane raises either flag. wr_en_o equals valid_o with no exception.
- R7: summary_o is {all_true, 0, all_false, 0} (bit 3 is all_true, bit 1 is all_false) when rec_i is 1 and there is no exception. It is 4'b0000 otherwise.
- R8: snan_sticky_o and vc_sticky_o are set by an accepted operation that raises the matching flag. fx_sticky_o is set when either flag is raised. All three stay set until reset.
- R9: A cycle with valid_i at 0 leaves valid_o and wr_en_o at 0. It changes neither the stickies nor mask_o and summary_o.
- R10: While rst_ni is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation accepted this cycle |
| op_a_i | input | 128 | Operand A, four single-precision lanes |
| op_b_i | input | 128 | Operand B, four single-precision lanes |
| inv_en_i | input | 1 | Invalid-operation exception enable |
| rec_i | input | 1 | Request condition summary |
| valid_o | output | 1 | Result of an accepted operation present |
| mask_o | output | 128 | Per-lane greater-than mask |
| wr_en_o | output | 1 | Target write permitted |
| summary_o | output | 4 | Condition summary {all_true,0,all_false,0} |
| snan_sticky_o | output | 1 | Sticky signaling-NaN flag |
| vc_sticky_o | output | 1 | Sticky invalid-compare flag |
| fx_sticky_o | output | 1 | Sticky any-exception flag |

## Verification
The bench sweeps every ordered pair from a set of twenty edge values, both infinities, quiet and signaling NaNs of either sign, with the enable at 0 and at 1, and then adds random vectors. A design that orders negatives by raw magnitude would report -2 greater than -1. One that treats the two zeros by their sign bits would mark -0 less than +0. A design that tests bit 22 the wrong way round would swap the two flags. If the invalid-compare flag is raised on signaling NaNs under an enabled exception, the sticky bit becomes wrong. A design that ignores the enable would write the target when it should not, or return a nonzero summary.

// File: rtl/vsp_cmp_pkg.sv
package vsp_cmp_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int LANE_W = 1 + EXP_W + FRAC_W;
  localparam int MAG_W  = EXP_W + FRAC_W;
  localparam int SUM_W  = 4;

  typedef struct packed {
    logic             sign;
    logic             zero;
    logic             nan;
    logic             snan;
    logic [MAG_W-1:0] mag;
  } lane_cls_t;
endpackage

// File: rtl/vsp_lane_class.sv
module vsp_lane_class
  import vsp_cmp_pkg::*;
(
  input  logic [LANE_W-1:0] word_i,
  output lane_cls_t         cls_o
);
  logic [EXP_W-1:0]  exp_w;
  logic [FRAC_W-1:0] frac_w;

  assign exp_w  = word_i[LANE_W-2 -: EXP_W];
  assign frac_w = word_i[FRAC_W-1:0];

  always_comb begin
    cls_o.sign = word_i[LANE_W-1];
    cls_o.mag  = word_i[MAG_W-1:0];
    cls_o.zero = (word_i[MAG_W-1:0] == '0);
    cls_o.nan  = (&exp_w) && (|frac_w);
    // quiet bit is the fraction MSB
    cls_o.snan = cls_o.nan && !frac_w[FRAC_W-1];
  end
endmodule

// File: rtl/vsp_lane_gt.sv
module vsp_lane_gt
  import vsp_cmp_pkg::*;
(
  input  lane_cls_t a_i,
  input  lane_cls_t b_i,
  input  logic      inv_en_i,
  output logic      gt_o,
  output logic      snan_o,
  output logic      vc_o
);
  logic unord, both_zero, mag_gt, mag_lt;

  assign unord     = a_i.nan | b_i.nan;
  assign both_zero = a_i.zero & b_i.zero;
  assign mag_gt    = a_i.mag > b_i.mag;
  assign mag_lt    = a_i.mag < b_i.mag;

  always_comb begin
    if (unord || both_zero)      gt_o = 1'b0;
    else if (a_i.sign != b_i.sign) gt_o = !a_i.sign;
    else if (a_i.sign)           gt_o = mag_lt;  // negatives: reversed
    else                         gt_o = mag_gt;
  end

  assign snan_o = a_i.snan | b_i.snan;
  assign vc_o   = snan_o ? !inv_en_i : unord;

  always_comb begin
    if (a_i.nan || b_i.nan) a_r4_nan_never_gt: assert (!gt_o);
    if (a_i.zero && b_i.zero) a_r3_zeros_equal: assert (!gt_o);
    if (a_i.snan && inv_en_i) a_r5_snan_en_no_vc: assert (!vc_o && snan_o);
  end
endmodule

// File: rtl/vsp_vec_reduce.sv
module vsp_vec_reduce
  import vsp_cmp_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0] gt_i,
  input  logic [LANES-1:0] snan_i,
  input  logic [LANES-1:0] vc_i,
  input  logic             inv_en_i,
  input  logic             rec_i,
  output logic             exc_o,
  output logic             any_snan_o,
  output logic             any_vc_o,
  output logic [SUM_W-1:0] summary_o
);
  logic all_true, all_false;

  assign all_true   = &gt_i;
  assign all_false  = ~|gt_i;
  assign any_snan_o = |snan_i;
  assign any_vc_o   = |vc_i;
  assign exc_o      = inv_en_i & (any_snan_o | any_vc_o);

  always_comb begin
    if (rec_i && !exc_o) summary_o = {all_true, 1'b0, all_false, 1'b0};
    else                 summary_o = '0;
  end
endmodule

// File: rtl/vsp_gt_cmp.sv
module vsp_gt_cmp
  import vsp_cmp_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [LANES*LANE_W-1:0] op_a_i,
  input  logic [LANES*LANE_W-1:0] op_b_i,
  input  logic                    inv_en_i,
  input  logic                    rec_i,
  output logic                    valid_o,
  output logic [LANES*LANE_W-1:0] mask_o,
  output logic                    wr_en_o,
  output logic [SUM_W-1:0]        summary_o,
  output logic                    snan_sticky_o,
  output logic                    vc_sticky_o,
  output logic                    fx_sticky_o
);
  localparam int VEC_W = LANES * LANE_W;

  lane_cls_t          cls_a [LANES];
  lane_cls_t          cls_b [LANES];
  logic [LANES-1:0]   gt_l, snan_l, vc_l;
  logic [VEC_W-1:0]   mask_d;
  logic [SUM_W-1:0]   summary_d;
  logic               exc_d, any_snan, any_vc;
  logic               valid_q, exc_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    vsp_lane_class u_cls_a (.word_i(op_a_i[g*LANE_W +: LANE_W]), .cls_o(cls_a[g]));
    vsp_lane_class u_cls_b (.word_i(op_b_i[g*LANE_W +: LANE_W]), .cls_o(cls_b[g]));
    vsp_lane_gt u_gt (
      .a_i(cls_a[g]), .b_i(cls_b[g]), .inv_en_i(inv_en_i),
      .gt_o(gt_l[g]), .snan_o(snan_l[g]), .vc_o(vc_l[g])
    );
    assign mask_d[g*LANE_W +: LANE_W] = {LANE_W{gt_l[g]}};
  end

  vsp_vec_reduce #(.LANES(LANES)) u_red (
    .gt_i(gt_l), .snan_i(snan_l), .vc_i(vc_l),
    .inv_en_i(inv_en_i), .rec_i(rec_i),
    .exc_o(exc_d), .any_snan_o(any_snan), .any_vc_o(any_vc),
    .summary_o(summary_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q       <= 1'b0;
      exc_q         <= 1'b0;
      mask_o        <= '0;
      summary_o     <= '0;
      snan_sticky_o <= 1'b0;
      vc_sticky_o   <= 1'b0;
      fx_sticky_o   <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        exc_q         <= exc_d;
        mask_o        <= mask_d;
        summary_o     <= summary_d;
        snan_sticky_o <= snan_sticky_o | any_snan;
        vc_sticky_o   <= vc_sticky_o | any_vc;
        fx_sticky_o   <= fx_sticky_o | any_snan | any_vc;
      end
    end
  end

  assign valid_o = valid_q;
  assign wr_en_o = valid_q & ~exc_q;

  a_r6_wr_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> valid_o);
  a_r8_snan_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(snan_sticky_o) && !$fell(vc_sticky_o) && !$fell(fx_sticky_o));
  a_r8_fx_covers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snan_sticky_o | vc_sticky_o) |-> fx_sticky_o);
  a_r7_summary_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(summary_o[3] && summary_o[1]) && !summary_o[2] && !summary_o[0]);
  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(mask_o) && $stable(summary_o) && !valid_o);
endmodule

// File: tb/sim_vsp_gt_cmp.sv
`timescale 1ns/1ps
module sim_vsp_gt_cmp;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [127:0] op_a_i = '0, op_b_i = '0;
  logic         inv_en_i = 1'b0, rec_i = 1'b0;
  logic         valid_o, wr_en_o, snan_sticky_o, vc_sticky_o, fx_sticky_o;
  logic [127:0] mask_o;
  logic [3:0]   summary_o;

  int n_chk = 0, n_fail = 0;
  logic m_snan = 0, m_vc = 0, m_fx = 0;

  always #2.5 clk_i = ~clk_i;

  vsp_gt_cmp u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic logic [31:0] spec(input int k);
    case (k)
      0: return 32'h0000_0000;  1: return 32'h8000_0000;
      2: return 32'h0000_0001;  3: return 32'h8000_0001;
      4: return 32'h007F_FFFF;  5: return 32'h0080_0000;
      6: return 32'h3F80_0000;  7: return 32'hBF80_0000;
      8: return 32'h3F80_0001;  9: return 32'h4000_0000;
      10: return 32'hC000_0000; 11: return 32'h7F7F_FFFF;
      12: return 32'hFF7F_FFFF; 13: return 32'h7F80_0000;
      14: return 32'hFF80_0000; 15: return 32'h7FC0_0000;
      16: return 32'hFFC0_0001; 17: return 32'h7F80_0001;
      18: return 32'hFFA0_0000; default: return 32'hBF80_0001;
    endcase
  endfunction

  function automatic bit is_nan(input logic [31:0] w);
    return (w[30:23] == 8'hFF) && (w[22:0] != 0);
  endfunction

  function automatic real to_real(input logic [31:0] w);
    int  e = int'(w[30:23]);
    real f = real'(w[22:0]);
    real m;
    if (e == 255)    m = 1.0e300;
    else if (e == 0) m = f * (2.0 ** (-149));
    else             m = (1.0 + f / 8388608.0) * (2.0 ** (e - 127));
    return w[31] ? -m : m;
  endfunction

  // one accepted operation, checked one cycle later
  task automatic txn(input logic [127:0] a, input logic [127:0] b, input bit inv, input bit rec);
    logic [127:0] e_mask = '0;
    bit any_s = 0, any_v = 0, at = 1, af = 1, exc;
    logic [3:0] e_sum;
    for (int l = 0; l < 4; l++) begin
      logic [31:0] wa = a[l*32 +: 32], wb = b[l*32 +: 32];
      bit sa = is_nan(wa) && !wa[22], sb = is_nan(wb) && !wb[22];
      bit qa = is_nan(wa) && wa[22],  qb = is_nan(wb) && wb[22];
      bit gt = !is_nan(wa) && !is_nan(wb) && (to_real(wa) > to_real(wb));
      if (gt) begin e_mask[l*32 +: 32] = '1; af = 0; end else at = 0;
      if (sa || sb) begin any_s = 1; if (!inv) any_v = 1; end
      else if (qa || qb) any_v = 1;
    end
    exc   = inv && (any_s || any_v);
    e_sum = (rec && !exc) ? {at, 1'b0, af, 1'b0} : 4'b0;
    m_snan |= any_s; m_vc |= any_v; m_fx |= any_s | any_v;
    op_a_i = a; op_b_i = b; inv_en_i = inv; rec_i = rec; valid_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    chk(valid_o === 1'b1, "R1 valid_o", 128'(valid_o), 128'd1);
    chk(mask_o === e_mask, "R1/R2/R3/R4 mask_o", mask_o, e_mask);
    chk(wr_en_o === !exc, "R6 wr_en_o", 128'(wr_en_o), 128'(!exc));
    chk(summary_o === e_sum, "R7 summary_o", 128'(summary_o), 128'(e_sum));
    chk({snan_sticky_o, vc_sticky_o, fx_sticky_o} === {m_snan, m_vc, m_fx},
        "R5/R8 stickies", 128'({snan_sticky_o, vc_sticky_o, fx_sticky_o}), 128'({m_snan, m_vc, m_fx}));
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [127:0] last_mask;
    logic [3:0]   last_sum;
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk({valid_o, wr_en_o, summary_o, snan_sticky_o, vc_sticky_o, fx_sticky_o} === '0 && mask_o === '0,
        "R10 reset outputs", mask_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R7 all-true / all-false / mixed, no NaN so R8 stickies stay zero
    txn({4{32'h4000_0000}}, {4{32'h3F80_0000}}, 1'b0, 1'b1);
    txn({4{32'h3F80_0000}}, {4{32'h4000_0000}}, 1'b0, 1'b1);
    txn({32'h4000_0000, 32'h0, 32'hBF80_0000, 32'h3F80_0001},
        {32'h3F80_0000, 32'h8000_0000, 32'hC000_0000, 32'h3F80_0000}, 1'b1, 1'b1);
    txn({4{32'h4000_0000}}, {4{32'h3F80_0000}}, 1'b0, 1'b0);

    // R2/R3/R4/R5 sweep of all ordered special pairs, enable 0 then 1
    for (int inv = 0; inv < 2; inv++)
      for (int v = 0; v < 100; v++) begin
        logic [127:0] a = '0, b = '0;
        for (int l = 0; l < 4; l++) begin
          a[l*32 +: 32] = spec((4*v + l) / 20);
          b[l*32 +: 32] = spec((4*v + l) % 20);
        end
        txn(a, b, inv[0], (inv == 0) || v[0]);
      end

    // R9 idle cycle leaves outputs alone
    last_mask = mask_o; last_sum = summary_o;
    valid_i = 1'b0; op_a_i = '1; op_b_i = '0;
    @(posedge clk_i); @(negedge clk_i);
    chk(valid_o === 1'b0 && wr_en_o === 1'b0, "R9 idle valid/wr_en", 128'({valid_o, wr_en_o}), '0);
    chk(mask_o === last_mask && summary_o === last_sum, "R9 idle hold", mask_o, last_mask);
    chk({snan_sticky_o, vc_sticky_o, fx_sticky_o} === {m_snan, m_vc, m_fx},
        "R9 idle stickies", 128'({snan_sticky_o, vc_sticky_o, fx_sticky_o}), 128'({m_snan, m_vc, m_fx}));

    // R1/R2 random vectors
    for (int r = 0; r < 600; r++) begin
      logic [127:0] a, b;
      for (int l = 0; l < 4; l++) begin
        a[l*32 +: 32] = $urandom;
        b[l*32 +: 32] = (r % 3 == 0) ? (a[l*32 +: 32] ^ (32'h1 << ($urandom % 32))) : $urandom;
      end
      txn(a, b, 1'($urandom), 1'($urandom));
    end

    // R8 stickies clear only through reset
    valid_i = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk({snan_sticky_o, vc_sticky_o, fx_sticky_o} === 3'b000, "R8/R10 sticky reset",
        128'({snan_sticky_o, vc_sticky_o, fx_sticky_o}), '0);
    finish_up();
  end
endmodule